// File: doc/BRIEF.md
# Sequential Strip Noise-Rate Scanner

This block measures the background counting rate of detector readout strips, one strip per plane at a time, while no physics event is being read out. It watches 128 digitized strip lines, 64 in an X plane and 64 in a Y plane. In each gate window it picks the strip at the current scan index in both planes. It counts the rising edges of those two strips and, at the end of the window, publishes a tagged record. The record carries both counts, an overflow flag per plane, the two channel IDs and a window sequence number. The scan index then steps to the next strip.

The gate window is a programmable number of ticks. Each tick is `PRESCALE` clock cycles. At the default 50 MHz clock the tick rate is 1 Hz, and the nominal gate is 10 ticks. A high event-busy input pauses scanning. The window that was open is dropped, and a fresh full-length window starts when busy falls. A downstream packer samples the record on the single-cycle valid strobe.

Top module: `strip_noise_scan`

## Requirements
- R1: Each strip line passes through a two-flop synchronizer. Every rising edge of the selected strip that is seen inside a window adds one to that plane's count.
- R2: In a window only the strip at the current scan index is counted in each plane. Edges on all other strips leave the record unchanged.
- R3: A count stops at 2^CNT_W-1. The plane's overflow flag in the record is 1 exactly when at least one edge arrived while the count was already at that maximum. Count and flag both restart from 0 in every window.
- R4: The X channel ID is the scan index (0..63). The Y channel ID is 64 plus the scan index (64..127), so bit 6 of the 8-bit ID marks the Y plane.
- R5: A window lasts `gate_ticks_i` × `PRESCALE` cycles. The gate value is taken in the first cycle of the window and later changes do not affect that window. A gate value of 0 acts as 1.
- R6: The first window after reset uses index 0. After each completed window the index advances by one and wraps from 63 to 0.
- R7: The sequence number is SEQ_W (32) bits wide. It is 0 in the first record after reset and rises by one in each following record.
- R8: `rec_valid_o` is high for exactly one cycle, the cycle after the last cycle of a window. All record fields hold their values until the next record.
- R9: While `busy_i` is high nothing is counted and no record is issued, and the index and sequence number stay unchanged. Edges seen before busy rose are discarded. A full-length window starts in the first cycle with busy low.
- R10: During and after reset, before the first record, `rec_valid_o`, the counts, the flags, the IDs and the sequence number are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| busy_i | input | 1 | Event readout in progress; suspends and restarts the window |
| gate_ticks_i | input | 8 | Window length in prescaler ticks (0 acts as 1) |
| strip_x_i | input | 64 | X-plane strip lines, asynchronous |
| strip_y_i | input | 64 | Y-plane strip lines, asynchronous |
| rec_valid_o | output | 1 | One-cycle record strobe |
| rec_seq_o | output | 32 | Window sequence number |
| rec_x_id_o | output | 8 | X channel ID |
| rec_x_count_o | output | 24 | X strip edge count |
| rec_x_ovf_o | output | 1 | X count saturated and an edge was lost |
| rec_y_id_o | output | 8 | Y channel ID |
| rec_y_count_o | output | 24 | Y strip edge count |
| rec_y_ovf_o | output | 1 | Y count saturated and an edge was lost |

## Verification
The assertions assume that `busy_i` is synchronous to the clock and defined at every edge, and that reset is held for at least one clock edge. They also assume that `PRESCALE` is at least 2, so two records can never fall in adjacent cycles. The bench drives busy and the gate only at falling edges and holds busy low throughout reset. Its strip pulses stay high for two cycles and low for two, so each pulse survives the synchronizer as a single edge. All pulses are placed well inside a window, so no edge straddles a window boundary.

// File: rtl/nrm_pkg.sv
package nrm_pkg;
  localparam int unsigned NUM_PLANES = 2;
  localparam int unsigned PLANE_X    = 0;
  localparam int unsigned PLANE_Y    = 1;
endpackage

// File: rtl/nrm_sync.sv
module nrm_sync #(
  parameter int unsigned W = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] s1_q, s2_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= '0;
      s2_q   <= '0;
      prev_q <= '0;
    end else begin
      s1_q   <= d_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  // edge history kept on every strip so a scan step never sees a false edge
  assign rise_o = s2_q & ~prev_q;
endmodule

// File: rtl/nrm_plane_cnt.sv
module nrm_plane_cnt #(
  parameter int unsigned W     = 64,
  parameter int unsigned IDX_W = 6,
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [W-1:0]     rise_i,
  input  logic [IDX_W-1:0] sel_i,
  input  logic             run_i,
  input  logic             clear_i,
  output logic [CNT_W-1:0] cnt_nxt_o,
  output logic             ovf_nxt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;
  logic             hit, at_max;

  assign hit    = run_i & rise_i[sel_i];
  assign at_max = (cnt_q == CNT_MAX);

  always_comb begin
    cnt_nxt_o = cnt_q;
    ovf_nxt_o = ovf_q;
    if (hit) begin
      if (at_max) ovf_nxt_o = 1'b1;
      else        cnt_nxt_o = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (clear_i) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (run_i) begin
      cnt_q <= cnt_nxt_o;
      ovf_q <= ovf_nxt_o;
    end
  end
endmodule

// File: rtl/nrm_gate_timer.sv
module nrm_gate_timer #(
  parameter int unsigned PRESCALE = 50_000_000,
  parameter int unsigned TICK_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              busy_i,
  input  logic [TICK_W-1:0] gate_i,
  output logic              win_end_o
);
  localparam int unsigned PRE_W = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

  logic [PRE_W-1:0]  pre_q;
  logic [TICK_W-1:0] tick_q, gate_q, gate_cur;
  logic              start_q, tick;

  // gate sampled in the first cycle of each window; zero acts as one
  assign gate_cur  = start_q ? ((gate_i == '0) ? TICK_W'(1) : gate_i) : gate_q;
  assign tick      = (pre_q == PRE_LAST);
  assign win_end_o = !busy_i && tick && (tick_q == gate_cur - TICK_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q   <= '0;
      tick_q  <= '0;
      gate_q  <= TICK_W'(1);
      start_q <= 1'b1;
    end else if (busy_i) begin
      pre_q   <= '0;
      tick_q  <= '0;
      start_q <= 1'b1;
    end else begin
      start_q <= win_end_o;
      gate_q  <= gate_cur;
      if (tick) begin
        pre_q  <= '0;
        tick_q <= win_end_o ? '0 : tick_q + TICK_W'(1);
      end else begin
        pre_q  <= pre_q + PRE_W'(1);
      end
    end
  end
endmodule

// File: rtl/strip_noise_scan.sv
module strip_noise_scan
  import nrm_pkg::*;
#(
  parameter int unsigned STRIPS   = 64,
  parameter int unsigned CNT_W    = 24,
  parameter int unsigned ID_W     = 8,
  parameter int unsigned SEQ_W    = 32,
  parameter int unsigned TICK_W   = 8,
  parameter int unsigned PRESCALE = 50_000_000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              busy_i,
  input  logic [TICK_W-1:0] gate_ticks_i,
  input  logic [STRIPS-1:0] strip_x_i,
  input  logic [STRIPS-1:0] strip_y_i,
  output logic              rec_valid_o,
  output logic [SEQ_W-1:0]  rec_seq_o,
  output logic [ID_W-1:0]   rec_x_id_o,
  output logic [CNT_W-1:0]  rec_x_count_o,
  output logic              rec_x_ovf_o,
  output logic [ID_W-1:0]   rec_y_id_o,
  output logic [CNT_W-1:0]  rec_y_count_o,
  output logic              rec_y_ovf_o
);
  localparam int unsigned IDX_W = $clog2(STRIPS);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(STRIPS - 1);

  logic [STRIPS-1:0] strip_a [NUM_PLANES];
  logic [STRIPS-1:0] rise_a  [NUM_PLANES];
  logic [CNT_W-1:0]  cnt_nxt [NUM_PLANES];
  logic              ovf_nxt [NUM_PLANES];
  logic [CNT_W-1:0]  rec_cnt_q [NUM_PLANES];
  logic              rec_ovf_q [NUM_PLANES];
  logic [ID_W-1:0]   rec_id_q  [NUM_PLANES];
  logic [ID_W-1:0]   cur_id    [NUM_PLANES];

  logic [IDX_W-1:0] idx_q;
  logic [SEQ_W-1:0] seq_q, rec_seq_q;
  logic             win_end, rec_valid_q;

  assign strip_a[PLANE_X] = strip_x_i;
  assign strip_a[PLANE_Y] = strip_y_i;

  nrm_gate_timer #(
    .PRESCALE(PRESCALE),
    .TICK_W  (TICK_W)
  ) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .busy_i   (busy_i),
    .gate_i   (gate_ticks_i),
    .win_end_o(win_end)
  );

  for (genvar p = 0; p < NUM_PLANES; p++) begin : g_plane
    nrm_sync #(.W(STRIPS)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (strip_a[p]),
      .rise_o(rise_a[p])
    );

    nrm_plane_cnt #(
      .W    (STRIPS),
      .IDX_W(IDX_W),
      .CNT_W(CNT_W)
    ) u_cnt (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .rise_i   (rise_a[p]),
      .sel_i    (idx_q),
      .run_i    (!busy_i),
      .clear_i  (busy_i | win_end),
      .cnt_nxt_o(cnt_nxt[p]),
      .ovf_nxt_o(ovf_nxt[p])
    );

    // plane number sits above the strip index
    assign cur_id[p] = ID_W'(p * STRIPS) + ID_W'(idx_q);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rec_cnt_q[p] <= '0;
        rec_ovf_q[p] <= 1'b0;
        rec_id_q[p]  <= '0;
      end else if (win_end) begin
        rec_cnt_q[p] <= cnt_nxt[p];
        rec_ovf_q[p] <= ovf_nxt[p];
        rec_id_q[p]  <= cur_id[p];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q       <= '0;
      seq_q       <= '0;
      rec_seq_q   <= '0;
      rec_valid_q <= 1'b0;
    end else begin
      rec_valid_q <= win_end;
      if (win_end) begin
        idx_q     <= (idx_q == IDX_LAST) ? '0 : idx_q + IDX_W'(1);
        seq_q     <= seq_q + SEQ_W'(1);
        rec_seq_q <= seq_q;
      end
    end
  end

  assign rec_valid_o   = rec_valid_q;
  assign rec_seq_o     = rec_seq_q;
  assign rec_x_id_o    = rec_id_q[PLANE_X];
  assign rec_x_count_o = rec_cnt_q[PLANE_X];
  assign rec_x_ovf_o   = rec_ovf_q[PLANE_X];
  assign rec_y_id_o    = rec_id_q[PLANE_Y];
  assign rec_y_count_o = rec_cnt_q[PLANE_Y];
  assign rec_y_ovf_o   = rec_ovf_q[PLANE_Y];
endmodule

// File: rtl/strip_noise_scan_chk.sv
module strip_noise_scan_chk #(
  parameter int unsigned STRIPS = 64,
  parameter int unsigned CNT_W  = 24,
  parameter int unsigned ID_W   = 8,
  parameter int unsigned SEQ_W  = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             busy_i,
  input logic             rec_valid_o,
  input logic [SEQ_W-1:0] rec_seq_o,
  input logic [ID_W-1:0]  rec_x_id_o,
  input logic [CNT_W-1:0] rec_x_count_o,
  input logic             rec_x_ovf_o,
  input logic [ID_W-1:0]  rec_y_id_o,
  input logic [CNT_W-1:0] rec_y_count_o,
  input logic             rec_y_ovf_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [ID_W-1:0]  ID_LAST = ID_W'(STRIPS - 1);

  logic             seen_q;
  logic [SEQ_W-1:0] last_seq_q;
  logic [ID_W-1:0]  last_id_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q     <= 1'b0;
      last_seq_q <= '0;
      last_id_q  <= '0;
    end else if (rec_valid_o) begin
      seen_q     <= 1'b1;
      last_seq_q <= rec_seq_o;
      last_id_q  <= rec_x_id_o;
    end
  end

  p_valid_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o |=> !rec_valid_o);

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rec_valid_o |-> ($stable(rec_seq_o) && $stable(rec_x_count_o) && $stable(rec_y_count_o)));

  p_no_rec_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(busy_i) |-> !rec_valid_o);

  p_id_plane_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o |-> (rec_x_id_o < ID_W'(STRIPS)) && (rec_y_id_o == rec_x_id_o + ID_W'(STRIPS)));

  p_ovf_sat_x_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rec_valid_o && rec_x_ovf_o) |-> rec_x_count_o == CNT_MAX);

  p_ovf_sat_y_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rec_valid_o && rec_y_ovf_o) |-> rec_y_count_o == CNT_MAX);

  p_seq_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rec_valid_o && seen_q) |-> rec_seq_o == last_seq_q + SEQ_W'(1));

  p_idx_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rec_valid_o && seen_q) |->
      rec_x_id_o == ((last_id_q == ID_LAST) ? '0 : last_id_q + ID_W'(1)));
endmodule

bind strip_noise_scan strip_noise_scan_chk #(
  .STRIPS(STRIPS),
  .CNT_W (CNT_W),
  .ID_W  (ID_W),
  .SEQ_W (SEQ_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .busy_i       (busy_i),
  .rec_valid_o  (rec_valid_o),
  .rec_seq_o    (rec_seq_o),
  .rec_x_id_o   (rec_x_id_o),
  .rec_x_count_o(rec_x_count_o),
  .rec_x_ovf_o  (rec_x_ovf_o),
  .rec_y_id_o   (rec_y_id_o),
  .rec_y_count_o(rec_y_count_o),
  .rec_y_ovf_o  (rec_y_ovf_o)
);

// File: tb/tb_strip_noise_scan.sv
`timescale 1ns/1ps
module tb_strip_noise_scan;
  localparam int STRIPS = 64;
  localparam int CW     = 4;
  localparam int PRE    = 4;
  localparam int NVEC   = 8;
  // columns: x pulses, y pulses, noise pulses, expected x, expected y
  localparam int VEC [NVEC][5] = '{
    '{0, 0, 0, 0, 0}, '{1, 0, 2, 1, 0}, '{0, 2, 1, 0, 2}, '{3, 3, 0, 3, 3},
    '{2, 1, 3, 2, 1}, '{1, 1, 1, 1, 1}, '{3, 0, 2, 3, 0}, '{0, 3, 3, 0, 3}};

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              busy_i = 1'b0;
  logic [7:0]        gate_ticks_i = 8'd8;
  logic [STRIPS-1:0] strip_x_i = '0;
  logic [STRIPS-1:0] strip_y_i = '0;
  logic              rec_valid_o;
  logic [31:0]       rec_seq_o;
  logic [7:0]        rec_x_id_o, rec_y_id_o;
  logic [CW-1:0]     rec_x_count_o, rec_y_count_o;
  logic              rec_x_ovf_o, rec_y_ovf_o;

  int checks = 0, errors = 0, exp_idx = 0, exp_seq = 0;
  int cyc = 0, t0 = 0, c = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  strip_noise_scan #(.STRIPS(STRIPS), .CNT_W(CW), .PRESCALE(PRE)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .busy_i(busy_i), .gate_ticks_i(gate_ticks_i),
    .strip_x_i(strip_x_i), .strip_y_i(strip_y_i), .rec_valid_o(rec_valid_o),
    .rec_seq_o(rec_seq_o), .rec_x_id_o(rec_x_id_o), .rec_x_count_o(rec_x_count_o),
    .rec_x_ovf_o(rec_x_ovf_o), .rec_y_id_o(rec_y_id_o), .rec_y_count_o(rec_y_count_o),
    .rec_y_ovf_o(rec_y_ovf_o));

  task automatic check_eq(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_rec(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!rec_valid_o && n < 3000);
    if (!rec_valid_o) check_eq("R8 record timeout", 0, 1);
  endtask

  task automatic check_rec(input int ex, input int ey, input int ox, input int oy);
    check_eq("R1 R2 x count", rec_x_count_o, ex);
    check_eq("R1 R2 y count", rec_y_count_o, ey);
    check_eq("R3 x ovf", rec_x_ovf_o, ox);
    check_eq("R3 y ovf", rec_y_ovf_o, oy);
    check_eq("R4 R6 x id", rec_x_id_o, exp_idx);
    check_eq("R4 R6 y id", rec_y_id_o, STRIPS + exp_idx);
    check_eq("R7 seq", rec_seq_o, exp_seq);
    exp_idx = (exp_idx + 1) % STRIPS;
    exp_seq++;
  endtask

  // pulses of 2 cycles high, 2 low on the selected strips and on unselected ones
  task automatic pulses(input int nx, input int ny, input int nn);
    int m;
    m = nx > ny ? nx : ny;
    m = nn > m ? nn : m;
    for (int p = 0; p < m; p++) begin
      strip_x_i[exp_idx] = (p < nx);
      strip_y_i[exp_idx] = (p < ny);
      strip_x_i[(exp_idx + 1) % STRIPS] = (p < nn);
      strip_y_i[(exp_idx + 5) % STRIPS] = (p < nn);
      strip_x_i[(exp_idx + 63) % STRIPS] = (p < nn);
      repeat (2) @(negedge clk);
      strip_x_i = '0;
      strip_y_i = '0;
      repeat (2) @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R10 reset state
    check_eq("R10 valid in reset", rec_valid_o, 0);
    check_eq("R10 seq in reset", rec_seq_o, 0);
    check_eq("R10 x count in reset", rec_x_count_o, 0);
    check_eq("R10 y id in reset", rec_y_id_o, 0);
    rst_ni = 1'b1;

    // vector table, gate 8 ticks
    for (int k = 0; k < NVEC; k++) begin
      pulses(VEC[k][0], VEC[k][1], VEC[k][2]);
      wait_rec(c);
      check_rec(VEC[k][3], VEC[k][4], 0, 0);
    end

    // R8 strobe width
    @(negedge clk);
    check_eq("R8 valid one cycle", rec_valid_o, 0);
    wait_rec(c);
    check_rec(0, 0, 0, 0);

    // R5 window length and gate sampling
    wait_rec(c);
    check_eq("R5 window 8 ticks", c, 8 * PRE);
    check_rec(0, 0, 0, 0);
    gate_ticks_i = 8'd3;
    wait_rec(c);
    check_eq("R5 window 3 ticks", c, 3 * PRE);
    check_rec(0, 0, 0, 0);
    gate_ticks_i = 8'd0;
    wait_rec(c);
    check_eq("R5 gate zero acts as one", c, PRE);
    check_rec(0, 0, 0, 0);
    gate_ticks_i = 8'd5;
    repeat (3) @(negedge clk);
    gate_ticks_i = 8'd8;
    wait_rec(c);
    check_eq("R5 mid-window gate change ignored", c + 3, 5 * PRE);
    check_rec(0, 0, 0, 0);

    // R9 busy discards and restarts
    pulses(2, 2, 0);
    busy_i = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      check_eq("R9 no record while busy", rec_valid_o, 0);
    end
    busy_i = 1'b0;
    t0 = cyc;
    pulses(1, 2, 1);
    wait_rec(c);
    check_eq("R9 full window after busy", cyc - t0, 8 * PRE);
    check_rec(1, 2, 0, 0);

    // R3 saturation boundary
    gate_ticks_i = 8'd30;
    pulses(15, 16, 0);
    wait_rec(c);
    check_rec(15, 15, 0, 1);
    wait_rec(c);
    check_rec(0, 0, 0, 0);

    // R6 index wrap
    gate_ticks_i = 8'd1;
    for (int i = 0; i < 66; i++) begin
      wait_rec(c);
      if (exp_idx == 0) check_eq("R6 wrap to index 0", rec_x_id_o, 0);
      check_rec(0, 0, 0, 0);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule